// File: doc/BRIEF.md
# Dual-Mode Programmable Local-Oscillator Divider

This block divides a tuner's local-oscillator signal down to the comparison rate of a phase comparator. Two oscillator inputs arrive as single-cycle tick strobes in the block's clock domain: a high-band tick and a low-band tick. Two configuration bits pick one of three division paths. In the high band, the ticks pass through a fixed divide-by-two stage and then a pulse-swallow counter. In the low band, the ticks go either into the pulse-swallow counter directly or into a plain 12-bit programmable counter.

The pulse-swallow counter models a dual-modulus stage of modulus 16/17. The low four bits of the divisor are the swallow count and the upper twelve bits are the main count. The stage divides by 17 until the swallow count is used up, then by 16 for the rest of the main count, so the total equals the loaded divisor.

A divisor below the legal minimum for the selected path is raised to that minimum, and an error flag is set. A new divisor or path takes effect only when the current output period ends, so no period is ever cut short. A band indicator output reports which band is active, for use as a band switch.

Top module: `lo_prog_divider`

## Requirements
- R1: Reset is synchronous and active high. During reset `div_pulse` is 0, and the divisor and path present on the inputs are taken as the first active setting.
- R2: With `band_hi`=1 the low-band bit is ignored. One `div_pulse` follows every 2·N high-band ticks, where N is the active 16-bit divisor (legal 272..65535).
- R3: With `band_hi`=0 and `lo_swallow`=1, one `div_pulse` follows every N low-band ticks (legal 272..65535).
- R4: With `band_hi`=0 and `lo_swallow`=0, one `div_pulse` follows every N low-band ticks, where N is `divisor[11:0]` (legal 4..4095). Bits 15..12 are ignored.
- R5: A divisor below the path minimum (272 for both swallow paths, 4 for the direct path) is replaced by that minimum, and `clamp_err` reads 1 while that setting is active. A legal setting gives `clamp_err`=0.
- R6: Changes to `divisor`, `band_hi` or `lo_swallow` are taken only at the end of an output period. The period in progress finishes with the old setting, and the next period uses the values present on the tick that ends the period.
- R7: `div_pulse` is high for exactly one clock. It rises on the clock edge that samples the tick completing the count.
- R8: `band_pull` is 1 (pull the band line low) while the active setting selects the high band, and 0 (released) otherwise. It changes only at a period end or at reset.
- R9: Ticks on the input of the band that is not active have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_tick | input | 1 | One-cycle strobe per high-band oscillator edge |
| lo_tick | input | 1 | One-cycle strobe per low-band oscillator edge |
| band_hi | input | 1 | 1 selects the high-band path |
| lo_swallow | input | 1 | Low band only: 1 pulse-swallow path, 0 direct 12-bit path |
| divisor | input | 16 | Requested division value |
| div_pulse | output | 1 | One-clock pulse at the end of each full count |
| clamp_err | output | 1 | Active divisor was raised to the path minimum |
| band_pull | output | 1 | 1 = drive band line low (high band active), 0 = released |

## Verification
The hardest situation to reach is a setting change partway through a period. The bench must show that the old count still completes and that the new one applies only from the next period. To get there, the bench runs a known number of ticks after reset, then changes the divisor and band in the middle of the count. It counts the remaining ticks up to the pulse, and checks the band indicator both before and after that pulse. The swallow counts of 17 are exercised by divisors whose low four bits are nonzero. Their periods can only be matched when every group length adds up correctly.

// File: rtl/lodiv_pkg.sv
package lodiv_pkg;

    localparam int DIV_W   = 16;
    localparam int SWAL_W  = 4;
    localparam int DIR_W   = 12;
    localparam int SW_MOD  = 1 << SWAL_W;
    localparam int MIN_SW  = SW_MOD * (SW_MOD + 1);
    localparam int MIN_DIR = 4;

    typedef enum logic [1:0] {
        PATH_HI_SWALLOW = 2'd0,
        PATH_LO_SWALLOW = 2'd1,
        PATH_LO_DIRECT  = 2'd2
    } path_e;

    typedef struct packed {
        path_e             path;
        logic [DIV_W-1:0]  n;
        logic              clamped;
    } div_cfg_t;

    function automatic div_cfg_t shape_cfg(input logic band_hi,
                                           input logic lo_swallow,
                                           input logic [DIV_W-1:0] raw);
        div_cfg_t          c;
        logic [DIV_W-1:0]  floor_v;
        logic [DIV_W-1:0]  eff;
        if (band_hi)         c.path = PATH_HI_SWALLOW;
        else if (lo_swallow) c.path = PATH_LO_SWALLOW;
        else                 c.path = PATH_LO_DIRECT;
        if (c.path == PATH_LO_DIRECT) begin
            eff     = {{(DIV_W-DIR_W){1'b0}}, raw[DIR_W-1:0]};
            floor_v = DIV_W'(MIN_DIR);
        end else begin
            eff     = raw;
            floor_v = DIV_W'(MIN_SW);
        end
        c.clamped = (eff < floor_v);
        c.n       = c.clamped ? floor_v : eff;
        return c;
    endfunction

endpackage

// File: rtl/lodiv_cfg_reg.sv
module lodiv_cfg_reg
    import lodiv_pkg::*;
(
    input  logic     clk,
    input  logic     load,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (load) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/lodiv_prescale2.sv
module lodiv_prescale2 (
    input  logic clk,
    input  logic load,
    input  logic tick_in,
    output logic tick_out
);
    logic phase;

    assign tick_out = tick_in & phase;

    always_ff @(posedge clk) begin
        if (load)         phase <= 1'b0;
        else if (tick_in) phase <= ~phase;
    end
endmodule

// File: rtl/lodiv_swallow.sv
module lodiv_swallow #(
    parameter int N_W = 16,
    parameter int S_W = 4
) (
    input  logic           clk,
    input  logic           load,
    input  logic           tick,
    input  logic [N_W-1:0] ld_n,
    output logic           term
);
    localparam int M_W = N_W - S_W;
    localparam int MOD = 1 << S_W;

    logic [S_W:0]   pc;
    logic [M_W-1:0] main_left;
    logic [S_W-1:0] swal_left;
    logic [S_W:0]   last_pc;
    logic           grp_end;

    assign last_pc = (swal_left != '0) ? (S_W+1)'(MOD) : (S_W+1)'(MOD - 1);
    assign grp_end = tick && (pc == last_pc);
    assign term    = grp_end && (main_left == M_W'(1));

    always_ff @(posedge clk) begin
        if (load) begin
            pc        <= '0;
            main_left <= ld_n[N_W-1:S_W];
            swal_left <= ld_n[S_W-1:0];
        end else if (tick) begin
            if (grp_end) begin
                pc        <= '0;
                main_left <= main_left - M_W'(1);
                if (swal_left != '0) swal_left <= swal_left - S_W'(1);
            end else begin
                pc <= pc + (S_W+1)'(1);
            end
        end
    end
endmodule

// File: rtl/lodiv_direct.sv
module lodiv_direct #(
    parameter int C_W = 12
) (
    input  logic           clk,
    input  logic           load,
    input  logic           tick,
    input  logic [C_W-1:0] ld_n,
    output logic           term
);
    logic [C_W-1:0] cnt;
    logic [C_W-1:0] top_v;

    assign term = tick && (cnt == top_v);

    always_ff @(posedge clk) begin
        if (load) begin
            cnt   <= '0;
            top_v <= ld_n - C_W'(1);
        end else if (tick) begin
            cnt <= cnt + C_W'(1);
        end
    end
endmodule

// File: rtl/lo_prog_divider.sv
module lo_prog_divider
    import lodiv_pkg::*;
#(
    parameter int NW = DIV_W,
    parameter int SW = SWAL_W,
    parameter int DW = DIR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hi_tick,
    input  logic          lo_tick,
    input  logic          band_hi,
    input  logic          lo_swallow,
    input  logic [NW-1:0] divisor,
    output logic          div_pulse,
    output logic          clamp_err,
    output logic          band_pull
);
    div_cfg_t cfg_next;
    div_cfg_t cfg_q;
    logic     term;
    logic     load;
    logic     pre_in, pre_out;
    logic     sw_tick, dir_tick;
    logic     sw_term, dir_term;

    assign cfg_next = shape_cfg(band_hi, lo_swallow, divisor);
    assign load     = rst | term;

    lodiv_cfg_reg u_cfg (
        .clk    (clk),
        .load   (load),
        .cfg_in (cfg_next),
        .cfg_q  (cfg_q)
    );

    assign pre_in = hi_tick && (cfg_q.path == PATH_HI_SWALLOW);

    lodiv_prescale2 u_pre (
        .clk      (clk),
        .load     (load),
        .tick_in  (pre_in),
        .tick_out (pre_out)
    );

    always_comb begin
        sw_tick  = 1'b0;
        dir_tick = 1'b0;
        case (cfg_q.path)
            PATH_HI_SWALLOW: sw_tick  = pre_out;
            PATH_LO_SWALLOW: sw_tick  = lo_tick;
            PATH_LO_DIRECT:  dir_tick = lo_tick;
            default: ;
        endcase
    end

    lodiv_swallow #(.N_W(NW), .S_W(SW)) u_sw (
        .clk  (clk),
        .load (load),
        .tick (sw_tick),
        .ld_n (cfg_next.n),
        .term (sw_term)
    );

    lodiv_direct #(.C_W(DW)) u_dir (
        .clk  (clk),
        .load (load),
        .tick (dir_tick),
        .ld_n (cfg_next.n[DW-1:0]),
        .term (dir_term)
    );

    assign term = (cfg_q.path == PATH_LO_DIRECT) ? dir_term : sw_term;

    always_ff @(posedge clk) begin
        if (rst) div_pulse <= 1'b0;
        else     div_pulse <= term;
    end

    assign clamp_err = cfg_q.clamped;
    assign band_pull = (cfg_q.path == PATH_HI_SWALLOW);
endmodule

// File: rtl/lodiv_checker.sv
module lodiv_checker
    import lodiv_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     hi_tick,
    input logic     lo_tick,
    input logic     div_pulse,
    input logic     clamp_err,
    input logic     band_pull,
    input logic     term,
    input div_cfg_t cfg_q
);
    assert_one_clock_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    assert_pulse_needs_tick_R9: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(hi_tick || lo_tick));

    assert_band_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(band_pull) |-> $past(term || rst));

    assert_err_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(clamp_err) |-> $past(term || rst));

    assert_floor_held_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_q.n >= ((cfg_q.path == PATH_LO_DIRECT) ? DIV_W'(MIN_DIR) : DIV_W'(MIN_SW)));

    assert_direct_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.path == PATH_LO_DIRECT) |-> (cfg_q.n[DIV_W-1:DIR_W] == '0));
endmodule

bind lo_prog_divider lodiv_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .hi_tick   (hi_tick),
    .lo_tick   (lo_tick),
    .div_pulse (div_pulse),
    .clamp_err (clamp_err),
    .band_pull (band_pull),
    .term      (term),
    .cfg_q     (cfg_q)
);

// File: tb/sim_lo_prog_divider.sv
module sim_lo_prog_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hi_tick = 1'b0;
    logic        lo_tick = 1'b0;
    logic        band_hi = 1'b0;
    logic        lo_swallow = 1'b0;
    logic [15:0] divisor = 16'd272;
    logic        div_pulse, clamp_err, band_pull;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    lo_prog_divider u0 (
        .clk(clk), .rst(rst), .hi_tick(hi_tick), .lo_tick(lo_tick),
        .band_hi(band_hi), .lo_swallow(lo_swallow), .divisor(divisor),
        .div_pulse(div_pulse), .clamp_err(clamp_err), .band_pull(band_pull)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit b, input bit s, input int n);
        @(negedge clk);
        band_hi = b; lo_swallow = s; divisor = 16'(n);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // returns index of first tick followed by a pulse, 0 if none
    task automatic pump(input bit use_hi, input int count, output int first);
        first = 0;
        for (int i = 1; i <= count; i++) begin
            @(negedge clk);
            hi_tick = use_hi; lo_tick = !use_hi;
            @(negedge clk);
            hi_tick = 1'b0; lo_tick = 1'b0;
            if (div_pulse) begin
                first = i;
                break;
            end
        end
    endtask

    task automatic pulse_low_next(input string req);
        @(negedge clk);
        check(req, int'(div_pulse), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        band_hi = 1'b1; lo_swallow = 1'b1; divisor = 16'd272; rst = 1'b1;
        @(negedge clk);
        check("R1 pulse in reset", int'(div_pulse), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pulse after reset", int'(div_pulse), 0);
        check("R8 band after reset", int'(band_pull), 1);
        check("R5 err after legal reset", int'(clamp_err), 0);
    endtask

    task automatic t_high;
        int f;
        do_reset(1'b1, 1'b0, 272);
        pump(1'b1, 2000, f);
        check("R2 high N=272", f, 544);
        pulse_low_next("R7 width high");
        pump(1'b1, 2000, f);
        check("R2 high N=272 second period", f, 544);
        do_reset(1'b1, 1'b1, 1000);
        pump(1'b1, 3000, f);
        check("R2 high N=1000", f, 2000);
    endtask

    task automatic t_low_sw;
        int f;
        do_reset(1'b0, 1'b1, 275);
        pump(1'b0, 1000, f);
        check("R3 low swallow N=275", f, 275);
        do_reset(1'b0, 1'b1, 1000);
        pump(1'b0, 2000, f);
        check("R3 low swallow N=1000", f, 1000);
        pump(1'b0, 2000, f);
        check("R3 low swallow N=1000 second period", f, 1000);
    endtask

    task automatic t_direct;
        int f;
        do_reset(1'b0, 1'b0, 4);
        pump(1'b0, 100, f);
        check("R4 direct N=4", f, 4);
        pulse_low_next("R7 width direct");
        pump(1'b0, 100, f);
        check("R4 direct N=4 second period", f, 4);
        do_reset(1'b0, 1'b0, 4095);
        pump(1'b0, 5000, f);
        check("R4 direct N=4095", f, 4095);
        do_reset(1'b0, 1'b0, 16'h1005);
        pump(1'b0, 100, f);
        check("R4 direct upper bits ignored", f, 5);
        check("R5 no err for 0x1005 direct", int'(clamp_err), 0);
    endtask

    task automatic t_clamp;
        int f;
        do_reset(1'b0, 1'b1, 100);
        check("R5 err swallow low", int'(clamp_err), 1);
        pump(1'b0, 1000, f);
        check("R5 clamp to 272", f, 272);
        do_reset(1'b1, 1'b1, 0);
        check("R5 err high zero", int'(clamp_err), 1);
        pump(1'b1, 2000, f);
        check("R5 high clamp ratio 544", f, 544);
        do_reset(1'b0, 1'b0, 2);
        check("R5 err direct", int'(clamp_err), 1);
        divisor = 16'd10;
        check("R6 err held before boundary", int'(clamp_err), 1);
        pump(1'b0, 100, f);
        check("R5 direct clamp to 4", f, 4);
        check("R5 err cleared at boundary", int'(clamp_err), 0);
        pump(1'b0, 100, f);
        check("R6 new divisor 10 applies", f, 10);
    endtask

    task automatic t_boundary;
        int f;
        do_reset(1'b0, 1'b1, 300);
        pump(1'b0, 100, f);
        check("R6 no pulse mid count", f, 0);
        divisor = 16'd280; band_hi = 1'b1;
        @(negedge clk);
        check("R8 band held mid period", int'(band_pull), 0);
        pump(1'b0, 500, f);
        check("R6 old period completes", f, 200);
        check("R8 band switched at boundary", int'(band_pull), 1);
        pump(1'b1, 1000, f);
        check("R6 new high setting 280", f, 560);
    endtask

    task automatic t_ignore;
        int f;
        do_reset(1'b0, 1'b0, 8);
        pump(1'b1, 50, f);
        check("R9 high ticks ignored in low band", f, 0);
        pump(1'b0, 50, f);
        check("R9 low count unaffected", f, 8);
        do_reset(1'b1, 1'b1, 272);
        pump(1'b0, 300, f);
        check("R9 low ticks ignored in high band", f, 0);
        pump(1'b1, 1000, f);
        check("R9 high count unaffected", f, 544);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_high();
        t_low_sw();
        t_direct();
        t_clamp();
        t_boundary();
        t_ignore();
        finish_run();
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end
endmodule